// File: doc/BRIEF.md
# Planar video memory address mapper

This block sits between a host bus and a four-plane video memory. The memory is built as 32-bit words, and each plane is one byte lane of a word. For every host byte access in the legacy graphics window, the block takes the byte offset, the direction, the write byte and a set of mode bits. From these it works out, in the same cycle, the word address, the selected read plane, the lanes a write may change, and whether the word lies past the end of memory. The mode bits are: four-way chaining, host odd/even addressing, sequential plane mode, chained odd/even, doubleword, word/byte and read plane select, plus a four-bit plane write mask.

The block holds the memory itself, a synchronous RAM with per-lane write enables. Writes are committed on the edge that accepts them. Reads go through a two-state controller. `ST_IDLE` accepts a request. A read moves it to `ST_RD_CAP`, and it returns to `ST_IDLE` on the next edge unconditionally. A write leaves it in `ST_IDLE`. In `ST_RD_CAP` the fetched word is turned into a byte result. Unless the access is chained or out of range, the whole word is also copied into a 32-bit read latch. The shifts for word and doubleword mode depend on the odd/even bits. A read tests host odd/even addressing, while a write tests for sequential mode being off. This lets font data, which is written in sequential plane order, land in consecutive bytes without a shift.

Top module: `vmem_plane_mapper`

## Requirements
- R1: With `chain4` high, `plane_sel` equals `host_off[1:0]`, and those two bits are zero in the address before any shift.
- R2: With `chain4` low, `plane_sel` is `{read_map[1], host_off[0]}` when `host_oe` is high, and `read_map` otherwise.
- R3: On a write with `chain4` low and `seq_mode` low, `plane_en` is `map_mask` ANDed with 4'b1010 for an odd offset or 4'b0101 for an even one. With `seq_mode` high it is `map_mask` unchanged.
- R4: On a chained write, `plane_en` is `map_mask` ANDed with a one-hot of `plane_sel`. When that is zero, memory is left unchanged.
- R5: With `chain4` low and `chain_oe` high, bit 0 of the offset is cleared before any shift.
- R6: With `dword` high, the word address is the cleared offset shifted right by 2. Otherwise it is shifted right by 1 when odd/even is in force and `word_byte` is low. Odd/even counts as in force when `host_oe` is high on a read, or when `seq_mode` is low on a write. In all other cases the offset is not shifted.
- R7: `out_of_range` is high when the word address is at least MEM_BYTES/4. In that case `plane_en` is 0, a write changes nothing (including the aliased word), a read returns 8'hFF, and `read_latch` keeps its value.
- R8: A chained read returns byte lane `plane_sel` of the addressed word, and `read_latch` keeps its value.
- R9: A read with `chain4` low loads the whole 32-bit word into `read_latch` (lane n in bits 8n+7:8n) and returns lane `plane_sel`.
- R10: An in-range write stores `wr_data` in every lane enabled by `plane_en` and leaves the other lanes unchanged.
- R11: A read accepted on an edge moves the controller to `ST_RD_CAP`. `rd_valid` is high for exactly one cycle after the following edge, and a request presented in `ST_RD_CAP` is ignored.
- R12: After reset, `rd_valid`, `rd_data` and `read_latch` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| host_off | input | OFF_W | Host byte offset in the window |
| wr_data | input | 8 | Write byte |
| chain4 | input | 1 | Four-way chained addressing |
| host_oe | input | 1 | Host odd/even addressing (read path) |
| seq_mode | input | 1 | Sequential plane mode (write path) |
| chain_oe | input | 1 | Chained odd/even, clears offset bit 0 |
| dword | input | 1 | Doubleword address shift |
| word_byte | input | 1 | 0 = word shift allowed under odd/even |
| read_map | input | 2 | Read plane select |
| map_mask | input | 4 | Plane write mask |
| word_addr | output | OFF_W | Computed word address |
| plane_sel | output | 2 | Selected plane |
| plane_en | output | 4 | Lanes a write changes |
| out_of_range | output | 1 | Word address beyond memory |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result byte |
| read_latch | output | 32 | 32-bit read latch |

## Verification
`word_addr`, `plane_sel`, `plane_en` and `out_of_range` are combinational, so the bench samples them 1 ns after changing inputs with no request pending. A write takes effect on the edge that accepts it. Read results are due two edges after the request is presented: one edge fetches the word and the next captures it. The bench therefore drives on the falling edge and checks `rd_valid`, `rd_data` and `read_latch` on the falling edge after the capture edge. The ignored-request check presents a write during the capture cycle. It then reads the word back to confirm that the write had no effect.

// File: rtl/vpm_pkg.sv
package vpm_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_RD_CAP = 1'b1
    } vpm_state_t;
endpackage

// File: rtl/vpm_addr_map.sv
module vpm_addr_map
    import vpm_pkg::*;
#(
    parameter int OFF_W = 12,
    parameter int WORDS = 256
) (
    input  logic [OFF_W-1:0] host_off,
    input  logic             is_write,
    input  logic             chain4,
    input  logic             host_oe,
    input  logic             seq_mode,
    input  logic             chain_oe,
    input  logic             dword,
    input  logic             word_byte,
    input  logic [1:0]       read_map,
    input  logic [LANES-1:0] map_mask,
    output logic [OFF_W-1:0] word_addr,
    output logic [1:0]       plane,
    output logic [LANES-1:0] lane_en,
    output logic             oor
);
    localparam logic [OFF_W:0] LIMIT = (OFF_W+1)'(WORDS);

    logic [OFF_W-1:0] cleared;
    logic             oe_in_force;
    logic [LANES-1:0] mask_eff;
    logic [LANES-1:0] plane_hot;

    // one-hot decode of the selected plane
    for (genvar i = 0; i < LANES; i++) begin : g_hot
        assign plane_hot[i] = (plane == 2'(i));
    end

    always_comb begin
        cleared = host_off;
        if (chain4) begin
            plane        = host_off[1:0];
            cleared[1:0] = 2'b00;
        end else begin
            plane = host_oe ? {read_map[1], host_off[0]} : read_map;
            if (chain_oe) begin
                cleared[0] = 1'b0;
            end
        end
    end

    always_comb begin
        oe_in_force = is_write ? ~seq_mode : host_oe;
        if (dword) begin
            word_addr = cleared >> 2;
        end else if (oe_in_force && !word_byte) begin
            word_addr = cleared >> 1;
        end else begin
            word_addr = cleared;
        end
        oor = ({1'b0, word_addr} >= LIMIT);
    end

    always_comb begin
        mask_eff = map_mask;
        if (chain4) begin
            mask_eff = map_mask & plane_hot;
        end else if (!seq_mode) begin
            mask_eff = map_mask & (host_off[0] ? 4'b1010 : 4'b0101);
        end
        lane_en = (is_write && !oor) ? mask_eff : '0;
    end
endmodule

// File: rtl/vpm_ram.sv
module vpm_ram
    import vpm_pkg::*;
#(
    parameter int WORDS = 256,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANES-1:0]  we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              re,
    output logic [WORD_W-1:0] q
);
    logic [WORD_W-1:0] mem [WORDS];
    logic [WORD_W-1:0] bit_en;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign bit_en[i*LANE_W +: LANE_W] = {LANE_W{we[i]}};
    end

    always_ff @(posedge clk) begin
        if (|we) begin
            mem[idx] <= (mem[idx] & ~bit_en) | (wdata & bit_en);
        end
        if (re) begin
            q <= mem[idx];
        end
    end
endmodule

// File: rtl/vpm_ctrl.sv
module vpm_ctrl
    import vpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              chain4,
    input  logic              oor,
    input  logic [1:0]        plane,
    input  logic [LANES-1:0]  lane_en,
    input  logic [WORD_W-1:0] ram_q,
    output logic              ram_re,
    output logic [LANES-1:0]  ram_we,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic [WORD_W-1:0] latch
);
    vpm_state_t state, state_nx;
    logic       cap_c4, cap_oor;
    logic [1:0] cap_plane;
    logic       take;

    assign take   = (state == ST_IDLE) && req_valid;
    assign ram_re = take && !req_write;
    assign ram_we = (take && req_write) ? lane_en : '0;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (take && !req_write) state_nx = ST_RD_CAP;
            ST_RD_CAP: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            latch     <= '0;
            cap_c4    <= 1'b0;
            cap_oor   <= 1'b0;
            cap_plane <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (ram_re) begin
                cap_c4    <= chain4;
                cap_oor   <= oor;
                cap_plane <= plane;
            end
            if (state == ST_RD_CAP) begin
                rd_valid <= 1'b1;
                rd_data  <= cap_oor ? 8'hFF : ram_q[{cap_plane, 3'b000} +: 8];
                if (!cap_c4 && !cap_oor) begin
                    latch <= ram_q;
                end
            end
        end
    end

    // R11
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    // R11
    rd_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_CAP) |=> rd_valid);
    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_CAP && (cap_c4 || cap_oor)) |=> $stable(latch));
    // R7
    oor_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_CAP && cap_oor) |=> (rd_data == 8'hFF));
endmodule

// File: rtl/vmem_plane_mapper.sv
module vmem_plane_mapper
    import vpm_pkg::*;
#(
    parameter int OFF_W     = 12,
    parameter int MEM_BYTES = 1024,
    localparam int WORDS    = MEM_BYTES / LANES,
    localparam int IDX_W    = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [OFF_W-1:0] host_off,
    input  logic [7:0]       wr_data,
    input  logic             chain4,
    input  logic             host_oe,
    input  logic             seq_mode,
    input  logic             chain_oe,
    input  logic             dword,
    input  logic             word_byte,
    input  logic [1:0]       read_map,
    input  logic [3:0]       map_mask,
    output logic [OFF_W-1:0] word_addr,
    output logic [1:0]       plane_sel,
    output logic [3:0]       plane_en,
    output logic             out_of_range,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic [31:0]      read_latch
);
    logic [LANES-1:0]  ram_we;
    logic              ram_re;
    logic [WORD_W-1:0] ram_q;

    vpm_addr_map #(.OFF_W(OFF_W), .WORDS(WORDS)) u_map (
        .host_off  (host_off),
        .is_write  (req_write),
        .chain4    (chain4),
        .host_oe   (host_oe),
        .seq_mode  (seq_mode),
        .chain_oe  (chain_oe),
        .dword     (dword),
        .word_byte (word_byte),
        .read_map  (read_map),
        .map_mask  (map_mask),
        .word_addr (word_addr),
        .plane     (plane_sel),
        .lane_en   (plane_en),
        .oor       (out_of_range)
    );

    vpm_ram #(.WORDS(WORDS)) u_ram (
        .clk   (clk),
        .idx   (word_addr[IDX_W-1:0]),
        .we    (ram_we),
        .wdata ({LANES{wr_data}}),
        .re    (ram_re),
        .q     (ram_q)
    );

    vpm_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .chain4    (chain4),
        .oor       (out_of_range),
        .plane     (plane_sel),
        .lane_en   (plane_en),
        .ram_q     (ram_q),
        .ram_re    (ram_re),
        .ram_we    (ram_we),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .latch     (read_latch)
    );

    // R7
    oor_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_of_range |-> (plane_en == 4'b0000));
    // R4
    c4_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chain4 && req_write) |-> ($countones(plane_en) <= 1));
    // R3
    oe_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chain4 && req_write && !seq_mode)
            |-> ((plane_en & (host_off[0] ? 4'b0101 : 4'b1010)) == 4'b0000));
    // R1
    c4_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chain4 && dword) |-> (word_addr == (host_off >> 2)));
endmodule

// File: tb/vmem_plane_mapper_bench.sv
`timescale 1ns/1ps
module vmem_plane_mapper_bench;
    typedef struct packed {
        logic        c4, hoe, seq, coe, dw, wb;
        logic [1:0]  rmap;
        logic [3:0]  mm;
        logic        wr;
        logic [11:0] off;
        logic [11:0] ew;
        logic [1:0]  ep;
        logic [3:0]  een;
        logic        eo;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1,0,1,0,1,0,2'd0,4'hF,1'b0,12'h0A7, 12'h029,2'd3,4'h0,1'b0,4'd1},
        '{1,0,1,0,1,0,2'd0,4'hF,1'b1,12'h0A6, 12'h029,2'd2,4'h4,1'b0,4'd4},
        '{1,0,1,0,1,0,2'd0,4'hB,1'b1,12'h0A6, 12'h029,2'd2,4'h0,1'b0,4'd4},
        '{0,1,0,1,0,0,2'd2,4'hF,1'b0,12'h123, 12'h091,2'd3,4'h0,1'b0,4'd2},
        '{0,1,0,1,0,1,2'd2,4'hF,1'b0,12'h123, 12'h122,2'd3,4'h0,1'b1,4'd7},
        '{0,0,1,0,0,0,2'd1,4'hF,1'b0,12'h0FF, 12'h0FF,2'd1,4'h0,1'b0,4'd2},
        '{0,1,0,1,0,0,2'd0,4'hF,1'b1,12'h0C5, 12'h062,2'd1,4'hA,1'b0,4'd3},
        '{0,1,0,1,0,0,2'd0,4'h7,1'b1,12'h0C4, 12'h062,2'd0,4'h5,1'b0,4'd3},
        '{0,0,1,0,0,0,2'd0,4'h9,1'b1,12'h0C5, 12'h0C5,2'd0,4'h9,1'b0,4'd3},
        '{0,0,0,0,0,0,2'd0,4'hF,1'b1,12'h081, 12'h040,2'd0,4'hA,1'b0,4'd6},
        '{0,0,0,0,0,0,2'd2,4'hF,1'b0,12'h081, 12'h081,2'd2,4'h0,1'b0,4'd6},
        '{0,0,1,0,1,0,2'd0,4'hF,1'b0,12'h3FF, 12'h0FF,2'd0,4'h0,1'b0,4'd7},
        '{0,0,1,0,1,0,2'd0,4'hF,1'b0,12'h400, 12'h100,2'd0,4'h0,1'b1,4'd7},
        '{0,0,1,0,0,0,2'd0,4'hF,1'b1,12'h100, 12'h100,2'd0,4'h0,1'b1,4'd7},
        '{1,0,1,0,0,0,2'd0,4'hF,1'b0,12'h0FE, 12'h0FC,2'd2,4'h0,1'b0,4'd1},
        '{1,0,0,0,0,0,2'd0,4'hF,1'b1,12'h0FE, 12'h07E,2'd2,4'h4,1'b0,4'd1},
        '{0,0,1,1,0,0,2'd3,4'hF,1'b0,12'h0B7, 12'h0B6,2'd3,4'h0,1'b0,4'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] host_off = '0;
    logic [7:0]  wr_data = '0;
    logic        chain4 = 0, host_oe = 0, seq_mode = 1, chain_oe = 0, dword = 0, word_byte = 0;
    logic [1:0]  read_map = '0;
    logic [3:0]  map_mask = 4'hF;
    logic [11:0] word_addr;
    logic [1:0]  plane_sel;
    logic [3:0]  plane_en;
    logic        out_of_range, rd_valid;
    logic [7:0]  rd_data;
    logic [31:0] read_latch;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vmem_plane_mapper u_vmem_plane_mapper (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .host_off(host_off), .wr_data(wr_data), .chain4(chain4), .host_oe(host_oe),
        .seq_mode(seq_mode), .chain_oe(chain_oe), .dword(dword), .word_byte(word_byte),
        .read_map(read_map), .map_mask(map_mask), .word_addr(word_addr),
        .plane_sel(plane_sel), .plane_en(plane_en), .out_of_range(out_of_range),
        .rd_valid(rd_valid), .rd_data(rd_data), .read_latch(read_latch)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_mode(input logic c4, hoe, seq, coe, dw, wb);
        chain4 = c4; host_oe = hoe; seq_mode = seq; chain_oe = coe; dword = dw; word_byte = wb;
    endtask

    task automatic do_write(input logic [11:0] off, input logic [3:0] mm, input logic [7:0] d);
        @(negedge clk);
        host_off = off; map_mask = mm; wr_data = d; req_write = 1'b1; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] off, input logic [1:0] rm, input logic [7:0] exp_d,
                           input logic [31:0] exp_l, input string tag);
        @(negedge clk);
        host_off = off; read_map = rm; req_write = 1'b0; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(rd_valid == 1'b1, {tag, " rd_valid"}, 32'(rd_valid), 32'd1);
        chk(rd_data == exp_d, {tag, " rd_data"}, 32'(rd_data), 32'(exp_d));
        chk(read_latch == exp_l, {tag, " latch"}, read_latch, exp_l);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        chk(rd_valid == 1'b0, "R12 rd_valid", 32'(rd_valid), 0);
        chk(rd_data == 8'h00, "R12 rd_data", 32'(rd_data), 0);
        chk(read_latch == 32'h0, "R12 latch", read_latch, 0);

        // Combinational vector table (R1 R2 R3 R4 R5 R6 R7)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            set_mode(VECS[i].c4, VECS[i].hoe, VECS[i].seq, VECS[i].coe, VECS[i].dw, VECS[i].wb);
            read_map = VECS[i].rmap; map_mask = VECS[i].mm;
            req_write = VECS[i].wr; host_off = VECS[i].off;
            #1;
            chk(word_addr == VECS[i].ew, $sformatf("R%0d vec%0d word_addr", VECS[i].rq, i),
                32'(word_addr), 32'(VECS[i].ew));
            chk(plane_sel == VECS[i].ep, $sformatf("R%0d vec%0d plane_sel", VECS[i].rq, i),
                32'(plane_sel), 32'(VECS[i].ep));
            chk(plane_en == VECS[i].een, $sformatf("R%0d vec%0d plane_en", VECS[i].rq, i),
                32'(plane_en), 32'(VECS[i].een));
            chk(out_of_range == VECS[i].eo, $sformatf("R%0d vec%0d out_of_range", VECS[i].rq, i),
                32'(out_of_range), 32'(VECS[i].eo));
        end
        @(negedge clk);
        req_write = 1'b0;

        // R10 R9: planar write then masked write, planar reads
        set_mode(0, 0, 1, 0, 0, 0);
        do_write(12'h010, 4'hF, 8'h5A);
        do_write(12'h010, 4'h2, 8'hC3);
        do_read(12'h010, 2'd1, 8'hC3, 32'h5A5AC35A, "R9 R10 lane1");
        do_read(12'h010, 2'd0, 8'h5A, 32'h5A5AC35A, "R9 lane0");

        // R8: chained write/read, latch untouched
        set_mode(1, 0, 1, 0, 1, 0);
        do_write(12'h043, 4'hF, 8'h77);
        do_read(12'h043, 2'd0, 8'h77, 32'h5A5AC35A, "R8 chained read");
        // R4: zero mask on chained write drops it
        do_write(12'h043, 4'h7, 8'h11);
        do_read(12'h043, 2'd0, 8'h77, 32'h5A5AC35A, "R4 dropped write");

        // R9: planar read sees chained byte in lane 3
        set_mode(0, 0, 1, 0, 0, 0);
        do_read(12'h010, 2'd3, 8'h77, 32'h775AC35A, "R9 full word");

        // R3 R5 R6: odd/even write lands at word 0x20, lanes 1 and 3
        do_write(12'h020, 4'hF, 8'h00);
        set_mode(0, 1, 0, 1, 0, 0);
        do_write(12'h041, 4'hF, 8'h99);
        set_mode(0, 0, 1, 0, 0, 0);
        do_read(12'h020, 2'd3, 8'h99, 32'h99009900, "R3 R5 R6 odd-even write");

        // R7: out-of-range read and write
        do_read(12'h200, 2'd0, 8'hFF, 32'h99009900, "R7 oor read");
        do_write(12'h110, 4'hF, 8'hEE);
        do_read(12'h010, 2'd3, 8'h77, 32'h775AC35A, "R7 oor write alias");

        // R11: request during capture cycle ignored, one-cycle rd_valid
        @(negedge clk);
        host_off = 12'h010; read_map = 2'd3; req_write = 1'b0; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_write = 1'b1; map_mask = 4'hF; wr_data = 8'h00;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk(rd_valid == 1'b1, "R11 rd_valid due", 32'(rd_valid), 1);
        chk(rd_data == 8'h77, "R11 rd_data", 32'(rd_data), 32'h77);
        @(posedge clk);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R11 rd_valid pulse", 32'(rd_valid), 0);
        do_read(12'h010, 2'd3, 8'h77, 32'h775AC35A, "R11 ignored write");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule